// File: doc/BRIEF.md
# Legacy UART register interface

This block is the byte-wide register front end of an old-style serial port. A host reaches eight byte offsets over a plain strobe bus (offset, read strobe, write strobe, write data, read data). Behind the registers sit two byte streams owned by other logic: a receive source that shows a data-available flag and takes a pop strobe, and a transmit sink that takes a push strobe with a byte. Baud generation, shifting and buffering live elsewhere.

The block holds the interrupt enable, line control and modem control bytes. It keeps one pending flag for received data and one for transmitter ready, reports the highest-priority pending cause through an identification offset, and drives a single interrupt line. Transmit-ready interrupts are paced: enabling them raises one at once only when a minimum hold-off has elapsed since the previous one. Otherwise, like every other interrupt the block schedules, it arrives after a fixed delay. Both intervals are parameters in clock cycles. The status offset reports the transmitter as always empty. A divisor-latch access bit in line control redirects offsets 0 and 1 to a latch that accepts writes and does nothing with them.

Top module: `legacy_uart_regs`

## Requirements
- R1: After reset, the enable, line control and modem control reads return 0x00, the identification read returns 0x01, and irq is low.
- R2: The line control byte (offset 3) reads back as written. While its bit 7 is set, accesses to offsets 0 and 1 read 0x00, push nothing, pop nothing and leave the enable byte unchanged.
- R3: With bit 7 of line control clear, a read of offset 0 returns rx_data and pulses rx_pop when rx_avail is high; with rx_avail low it returns 0x00 and rx_pop stays low.
- R4: A read of offset 0 clears the pending receive flag on its clock edge. In the next cycle, if rx_avail is high (the source has applied the pop) and enable bit 0 is set, a receive interrupt is scheduled and becomes pending SCHED_DELAY cycles after that cycle's edge.
- R5: A read of offset 2 returns 0x04 while receive is pending, else 0x02 while transmit is pending, else 0x01. Returning 0x02 clears the pending transmit flag; returning 0x04 clears nothing.
- R6: A write of offset 0 with line-control bit 7 clear pulses tx_push with the written byte and clears the pending transmit flag; if enable bit 1 is set, transmit becomes pending SCHED_DELAY cycles after the write edge.
- R7: A write of offset 1 with bit 1 set makes transmit pending at the write edge when more than HOLDOFF_CYC clock edges have passed since transmit last became pending (or since reset); otherwise transmit becomes pending SCHED_DELAY cycles after the write edge.
- R8: A write of offset 1 with bit 1 clear cancels any scheduled transmit interrupt and clears the pending one. A write with bit 0 set while rx_avail is high schedules a receive interrupt SCHED_DELAY cycles later; any other write cancels the scheduled receive interrupt and clears the pending one.
- R9: A read of offset 5 returns 0x60 with bit 0 equal to rx_avail (bit 6 transmitter empty and bit 5 holding register empty always set).
- R10: Reads of offsets 6 and 7 return 0x00; writes to offsets 2 and 7 change no register and no pending flag.
- R11: A write of 0x1A (loopback bit 0x10 ORed with 0x0A) to offset 4 loads the modem control byte with 0x9A; any other value written there is ignored.
- R12: irq is high exactly when a receive or transmit interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, side effects at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset, combinational |
| rx_avail | input | 1 | Receive source holds a byte |
| rx_data | input | 8 | Byte offered by the receive source |
| rx_pop | output | 1 | Consume the offered receive byte |
| tx_push | output | 1 | Hand tx_data to the transmit sink |
| tx_data | output | 8 | Byte for the transmit sink |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a receive and a transmit interrupt pending together, followed by the receive re-arm after a pop while the transmit flag still holds irq high. The stimulus gets there by enabling both sources in one enable write once the hold-off has lapsed, so transmit rises at once and receive follows after the scheduling delay. It then drains the two queued bytes while reading the identification offset between the pops. The deferred transmit path is reached by a second enable write issued a few cycles after an immediate one. Each scheduled arrival is checked on both sides of its exact cycle.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

   localparam int OFS_W  = 3;
   localparam int BYTE_W = 8;

   typedef enum logic [OFS_W-1:0] {
      OFS_DATA    = 3'd0,
      OFS_IEN     = 3'd1,
      OFS_IDENT   = 3'd2,
      OFS_LINE    = 3'd3,
      OFS_MODEM   = 3'd4,
      OFS_LSTAT   = 3'd5,
      OFS_MSTAT   = 3'd6,
      OFS_SCRATCH = 3'd7
   } ofs_e;

   localparam logic [BYTE_W-1:0] ID_RX_DATA = 8'h04;
   localparam logic [BYTE_W-1:0] ID_TX_MT   = 8'h02;
   localparam logic [BYTE_W-1:0] ID_IDLE    = 8'h01;

   localparam logic [BYTE_W-1:0] LOOP_BIT    = 8'h10;
   localparam logic [BYTE_W-1:0] MODEM_MATCH = LOOP_BIT | 8'h0A;
   localparam logic [BYTE_W-1:0] MODEM_LOAD  = 8'h9A;

   localparam int LS_READY = 0;
   localparam int LS_HOLD  = 5;
   localparam int LS_EMPTY = 6;
   localparam int EN_RX    = 0;
   localparam int EN_TX    = 1;
   localparam int LATCH_B  = 7;

   // decoded bus accesses with side effects
   typedef struct packed {
      logic data_rd;
      logic data_wr;
      logic ien_wr;
      logic ident_rd;
      logic line_wr;
      logic modem_wr;
   } acc_t;

endpackage

// File: rtl/uart_bus_decode.sv
module uart_bus_decode
   import uart_regs_pkg::*;
(
   input  logic [OFS_W-1:0] addr,
   input  logic             rd,
   input  logic             wr,
   input  logic             latch_sel,
   output acc_t             acc
);

   logic at_data, at_ien;

   always_comb begin
      at_data = (addr == OFS_DATA) && !latch_sel;
      at_ien  = (addr == OFS_IEN)  && !latch_sel;
      acc.data_rd  = rd && at_data;
      acc.data_wr  = wr && at_data;
      acc.ien_wr   = wr && at_ien;
      acc.ident_rd = rd && (addr == OFS_IDENT);
      acc.line_wr  = wr && (addr == OFS_LINE);
      acc.modem_wr = wr && (addr == OFS_MODEM);
   end

endmodule

// File: rtl/uart_event_timer.sv
module uart_event_timer #(
   parameter int DELAY = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sched,
   input  logic cancel,
   output logic fire
);

   localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
   localparam logic [CW-1:0] LOAD = CW'(DELAY);
   localparam logic [CW-1:0] LAST = CW'(1);

   logic [CW-1:0] cnt_q;

   assign fire = (cnt_q == LAST) && !cancel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cancel)
         cnt_q <= '0;
      else if (sched)
         cnt_q <= LOAD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - LAST;
   end

endmodule

// File: rtl/uart_holdoff.sv
module uart_holdoff #(
   parameter int HOLDOFF = 22
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic elapsed
);

   localparam int HW = $clog2(HOLDOFF + 2);
   localparam logic [HW-1:0] SAT = HW'(HOLDOFF + 1);

   logic [HW-1:0] since_q;

   assign elapsed = (since_q == SAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_q <= '0;
      else if (restart)
         since_q <= '0;
      else if (!elapsed)
         since_q <= since_q + HW'(1);
   end

endmodule

// File: rtl/legacy_uart_regs.sv
module legacy_uart_regs
   import uart_regs_pkg::*;
#(
   parameter int HOLDOFF_CYC = 22,
   parameter int SCHED_DELAY = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFS_W-1:0]  bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              rx_avail,
   input  logic [BYTE_W-1:0] rx_data,
   output logic              rx_pop,
   output logic              tx_push,
   output logic [BYTE_W-1:0] tx_data,
   output logic              irq
);

   localparam int N_SRC = 2;
   localparam int SRC_RX = 0;
   localparam int SRC_TX = 1;

   if (SCHED_DELAY < 1) begin : g_bad_delay
      $error("SCHED_DELAY must be at least one cycle");
   end
   if (HOLDOFF_CYC < 0) begin : g_bad_hold
      $error("HOLDOFF_CYC must not be negative");
   end

   logic [BYTE_W-1:0] ier_q, lcr_q, mcr_q;
   logic              rx_pend_q, tx_pend_q, recheck_q;
   acc_t              acc;
   logic              hold_done;
   logic [N_SRC-1:0]  ev_sched, ev_cancel, ev_fire;
   logic              tx_now, tx_set, tx_clr, rx_set, rx_clr;

   uart_bus_decode u_dec (
      .addr      (bus_addr),
      .rd        (bus_rd),
      .wr        (bus_wr),
      .latch_sel (lcr_q[LATCH_B]),
      .acc       (acc)
   );

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      uart_event_timer #(.DELAY(SCHED_DELAY)) u_timer (
         .clk    (clk),
         .rst_n  (rst_n),
         .sched  (ev_sched[s]),
         .cancel (ev_cancel[s]),
         .fire   (ev_fire[s])
      );
   end

   uart_holdoff #(.HOLDOFF(HOLDOFF_CYC)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (tx_set),
      .elapsed (hold_done)
   );

   // transmit interrupt control
   always_comb begin
      tx_now = acc.ien_wr && bus_wdata[EN_TX] && hold_done;
      ev_sched[SRC_TX]  = (acc.data_wr && ier_q[EN_TX]) ||
                          (acc.ien_wr && bus_wdata[EN_TX] && !hold_done);
      ev_cancel[SRC_TX] = acc.ien_wr && !bus_wdata[EN_TX];
      tx_set = ev_fire[SRC_TX] || tx_now;
      tx_clr = acc.data_wr || ev_cancel[SRC_TX] ||
               (acc.ident_rd && !rx_pend_q && tx_pend_q);
   end

   // receive interrupt control
   always_comb begin
      ev_sched[SRC_RX]  = (recheck_q && rx_avail && ier_q[EN_RX]) ||
                          (acc.ien_wr && bus_wdata[EN_RX] && rx_avail);
      ev_cancel[SRC_RX] = acc.ien_wr && !(bus_wdata[EN_RX] && rx_avail);
      rx_set = ev_fire[SRC_RX];
      rx_clr = acc.data_rd || ev_cancel[SRC_RX];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q     <= '0;
         lcr_q     <= '0;
         mcr_q     <= '0;
         rx_pend_q <= 1'b0;
         tx_pend_q <= 1'b0;
         recheck_q <= 1'b0;
      end else begin
         if (acc.ien_wr)
            ier_q <= bus_wdata;
         if (acc.line_wr)
            lcr_q <= bus_wdata;
         if (acc.modem_wr && (bus_wdata == MODEM_MATCH))
            mcr_q <= MODEM_LOAD;
         rx_pend_q <= (rx_pend_q && !rx_clr) || rx_set;
         tx_pend_q <= (tx_pend_q && !tx_clr) || tx_set;
         recheck_q <= acc.data_rd;
      end
   end

   // read multiplexer
   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_DATA:  if (!lcr_q[LATCH_B] && rx_avail) bus_rdata = rx_data;
         OFS_IEN:   if (!lcr_q[LATCH_B]) bus_rdata = ier_q;
         OFS_IDENT: bus_rdata = rx_pend_q ? ID_RX_DATA :
                                tx_pend_q ? ID_TX_MT : ID_IDLE;
         OFS_LINE:  bus_rdata = lcr_q;
         OFS_MODEM: bus_rdata = mcr_q;
         OFS_LSTAT: begin
            bus_rdata[LS_READY] = rx_avail;
            bus_rdata[LS_HOLD]  = 1'b1;
            bus_rdata[LS_EMPTY] = 1'b1;
         end
         default:   bus_rdata = '0;
      endcase
   end

   assign rx_pop  = acc.data_rd && rx_avail;
   assign tx_push = acc.data_wr;
   assign tx_data = bus_wdata;
   assign irq     = rx_pend_q || tx_pend_q;

endmodule

// File: rtl/uart_regs_check.sv
module uart_regs_check
   import uart_regs_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [OFS_W-1:0]  bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [BYTE_W-1:0] bus_wdata,
   input logic [BYTE_W-1:0] bus_rdata,
   input logic              rx_avail,
   input logic              rx_pop,
   input logic              tx_push,
   input logic              irq,
   input logic [BYTE_W-1:0] lcr_q,
   input logic [BYTE_W-1:0] mcr_q
);

   assert_no_push_in_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> !lcr_q[LATCH_B]);

   assert_pop_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> rx_avail);

   assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFS_DATA && !lcr_q[LATCH_B] && !rx_avail) |-> bus_rdata == 8'h00);

   assert_cancel_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_IEN && !lcr_q[LATCH_B] && bus_wdata[1:0] == 2'b00) |=> !irq);

   assert_status_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFS_LSTAT) |-> (bus_rdata[6:5] == 2'b11 && bus_rdata[0] == rx_avail));

   assert_modem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_MODEM && bus_wdata != MODEM_MATCH) |=> $stable(mcr_q));

   assert_idle_ident_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFS_IDENT && !irq) |-> bus_rdata == ID_IDLE);

endmodule

bind legacy_uart_regs uart_regs_check u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .rx_avail  (rx_avail),
   .rx_pop    (rx_pop),
   .tx_push   (tx_push),
   .irq       (irq),
   .lcr_q     (lcr_q),
   .mcr_q     (mcr_q)
);

// File: tb/legacy_uart_regs_test.sv
module legacy_uart_regs_test;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD = 22;
   localparam int DLY  = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic       rx_avail, rx_pop, tx_push, irq;
   logic [7:0] rx_data, tx_data;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [7:0] rxq [4];
   int rx_cnt = 0, rx_idx = 0, push_n = 0;
   logic [7:0] last_tx = '0;

   assign rx_avail = (rx_idx < rx_cnt);
   assign rx_data  = (rx_idx < 4) ? rxq[rx_idx] : 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (rx_pop) rx_idx <= rx_idx + 1;
      if (tx_push) begin
         push_n  <= push_n + 1;
         last_tx <= tx_data;
      end
   end

   legacy_uart_regs #(.HOLDOFF_CYC(HOLD), .SCHED_DELAY(DLY)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_avail(rx_avail), .rx_data(rx_data), .rx_pop(rx_pop),
      .tx_push(tx_push), .tx_data(tx_data), .irq(irq)
   );

   typedef struct packed {
      logic       wr;
      logic [2:0] addr;
      logic [7:0] data;
      logic [7:0] expect_v;
      logic [7:0] req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 3'd3, 8'h03, 8'h00, 8'd2},   // R2 line control write
      '{1'b0, 3'd3, 8'h00, 8'h03, 8'd2},   // R2 line control readback
      '{1'b1, 3'd4, 8'h1A, 8'h00, 8'd11},  // R11 loopback pattern
      '{1'b0, 3'd4, 8'h00, 8'h9A, 8'd11},  // R11 loaded value
      '{1'b1, 3'd4, 8'h55, 8'h00, 8'd11},  // R11 other value ignored
      '{1'b0, 3'd4, 8'h00, 8'h9A, 8'd11},  // R11 unchanged
      '{1'b0, 3'd6, 8'h00, 8'h00, 8'd10},  // R10 modem status zero
      '{1'b1, 3'd7, 8'hFF, 8'h00, 8'd10},  // R10 scratch write ignored
      '{1'b0, 3'd7, 8'h00, 8'h00, 8'd10},  // R10 scratch reads zero
      '{1'b0, 3'd5, 8'h00, 8'h60, 8'd9},   // R9 status with no data
      '{1'b1, 3'd2, 8'hC7, 8'h00, 8'd10},  // R10 offset 2 write ignored
      '{1'b0, 3'd2, 8'h00, 8'h01, 8'd10},  // R10 nothing became pending
      '{1'b0, 3'd1, 8'h00, 8'h00, 8'd2},   // R2 enable still zero
      '{1'b0, 3'd3, 8'h00, 8'h03, 8'd2}    // R2 line control kept
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int pn;
      rxq[0] = 8'hA1; rxq[1] = 8'hB2; rxq[2] = 8'h00; rxq[3] = 8'h00;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 irq", {7'd0, irq}, 8'h00);
      rd_reg(3'd2, v); chk("R1 ident", v, 8'h01);
      rd_reg(3'd1, v); chk("R1 enable", v, 8'h00);
      rd_reg(3'd3, v); chk("R1 line", v, 8'h00);
      rd_reg(3'd4, v); chk("R1 modem", v, 8'h00);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].wr) wr_reg(VECS[i].addr, VECS[i].data);
         else begin
            rd_reg(VECS[i].addr, v);
            checks++;
            if (v !== VECS[i].expect_v) begin
               errors++;
               $display("FAIL R%0d vector %0d actual %02h expected %02h",
                        VECS[i].req, i, v, VECS[i].expect_v);
            end
         end
      end

      // R7 immediate raise once the hold-off has lapsed
      idle(40);
      wr_reg(3'd1, 8'h02);
      chk("R7 immediate", {7'd0, irq}, 8'h01);
      rd_reg(3'd2, v); chk("R5 tx code", v, 8'h02);
      chk("R5 tx cleared by ident read", {7'd0, irq}, 8'h00);
      // R7 deferred raise inside the hold-off
      wr_reg(3'd1, 8'h02);
      idle(DLY - 1);
      chk("R7 not before delay", {7'd0, irq}, 8'h00);
      idle(1);
      chk("R7 after delay", {7'd0, irq}, 8'h01);

      // R8 transmit cancel and clear
      wr_reg(3'd1, 8'h00);
      chk("R8 tx cleared", {7'd0, irq}, 8'h00);
      wr_reg(3'd1, 8'h02);
      wr_reg(3'd1, 8'h00);
      idle(DLY + 4);
      chk("R8 scheduled tx cancelled", {7'd0, irq}, 8'h00);

      // R6 data write
      idle(40);
      wr_reg(3'd1, 8'h02);
      chk("R6 setup pending", {7'd0, irq}, 8'h01);
      wr_reg(3'd0, 8'h5A);
      chk("R6 write clears tx", {7'd0, irq}, 8'h00);
      chk("R6 push count", push_n[7:0], 8'h01);
      chk("R6 pushed byte", last_tx, 8'h5A);
      idle(DLY - 1);
      chk("R6 not before delay", {7'd0, irq}, 8'h00);
      idle(1);
      chk("R6 rescheduled tx", {7'd0, irq}, 8'h01);

      // R2 latch access redirects offsets 0 and 1
      wr_reg(3'd3, 8'h83);
      wr_reg(3'd0, 8'h33);
      wr_reg(3'd1, 8'h00);
      rd_reg(3'd1, v); chk("R2 latch read offset 1", v, 8'h00);
      chk("R2 no push in latch mode", push_n[7:0], 8'h01);
      chk("R2 irq kept in latch mode", {7'd0, irq}, 8'h01);
      wr_reg(3'd3, 8'h03);
      rd_reg(3'd1, v); chk("R2 enable unchanged", v, 8'h02);
      rd_reg(3'd2, v); chk("R5 tx code again", v, 8'h02);
      wr_reg(3'd1, 8'h00);

      // receive side
      rx_cnt = 2;
      rd_reg(3'd5, v); chk("R9 data ready", v, 8'h61);
      wr_reg(3'd3, 8'h80);
      rd_reg(3'd0, v); chk("R2 latch read offset 0", v, 8'h00);
      chk("R2 no pop in latch mode", rx_idx[7:0], 8'h00);
      wr_reg(3'd3, 8'h03);

      idle(40);
      wr_reg(3'd1, 8'h03);
      chk("R12 tx alone", {7'd0, irq}, 8'h01);
      idle(DLY);
      rd_reg(3'd2, v); chk("R5 rx priority", v, 8'h04);
      rd_reg(3'd2, v); chk("R5 rx not cleared by ident", v, 8'h04);
      rd_reg(3'd0, v); chk("R3 first byte", v, 8'hA1);
      chk("R3 one pop", rx_idx[7:0], 8'h01);
      chk("R12 tx still holds irq", {7'd0, irq}, 8'h01);
      rd_reg(3'd2, v); chk("R4 rx cleared by data read", v, 8'h02);
      chk("R12 irq low with none pending", {7'd0, irq}, 8'h00);
      idle(DLY - 2);
      chk("R4 rearm not early", {7'd0, irq}, 8'h00);
      idle(1);
      chk("R4 rearm after delay", {7'd0, irq}, 8'h01);
      rd_reg(3'd2, v); chk("R4 rearm code", v, 8'h04);
      rd_reg(3'd0, v); chk("R3 second byte", v, 8'hB2);
      chk("R4 read clears rx", {7'd0, irq}, 8'h00);
      idle(DLY + 4);
      chk("R4 no rearm when empty", {7'd0, irq}, 8'h00);
      pn = rx_idx;
      rd_reg(3'd0, v); chk("R3 empty read zero", v, 8'h00);
      chk("R3 no pop when empty", rx_idx[7:0], pn[7:0]);
      rd_reg(3'd5, v); chk("R9 no data", v, 8'h60);

      // R8 receive clear through the enable byte
      rxq[2] = 8'hC3;
      rx_cnt = 3;
      wr_reg(3'd1, 8'h01);
      idle(DLY);
      chk("R8 rx scheduled by enable", {7'd0, irq}, 8'h01);
      wr_reg(3'd1, 8'h00);
      chk("R8 rx cleared by enable", {7'd0, irq}, 8'h00);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule